// File: doc/BRIEF.md
# Crosspoint Serial Programming and Readback Port

This block is the serial front end of a crosspoint switch's configuration store. An external controller toggles a slow serial clock and presents one data bit per rising edge. The port assembles 14-bit programming words from these bits. Each word carries the number of the output to program and then the number of the input it should select. When the load flag comes with the last bit of a word, the port issues a one-cycle shadow-write request to the configuration memory, which sits outside this block.

Every bit that enters also leaves on the serial output exactly fourteen serial-clock edges later. Several devices can therefore share one serial chain and latch their words together. For diagnostics, one serial edge with scan-enable low captures the current selection of all 69 output slices from the memory's read vector. While scan-enable is high, the serial output then carries that snapshot, highest slice first and each word most-significant bit first. The port runs on a fast system clock. The serial inputs are synchronised to it and the serial clock's rising edges are found by edge detection. The port does anything only while serial mode is selected.

Top module: `xpt_serial_port`

## Requirements
- R1: After reset, sdout and wr_en are low, the word register and the 14-edge delay line hold zeros, and the readback register is empty, so it shifts out zeros.
- R2: Every serial input passes through a two-flop synchroniser. A serial-clock rise that is set up before system edge P takes effect at system edge P+2, and its results appear at the outputs after that edge.
- R3: Each serial-clock rise shifts one sdin bit, MSB first, into a 14-bit word. Bits 13..7 of the word are the output number and bits 6..0 are the input number. If load is high on the edge that brings the 14th bit, wr_out_id and wr_in_id take those two fields, including that last bit.
- R4: wr_en goes high for exactly one system cycle for each serial edge that has load high, and never on an edge with load low.
- R5: While scan_en is low, sdout equals the sdin bit that was sampled 14 serial edges earlier. It stays zero until 14 bits have been shifted in after reset.
- R6: A serial edge with scan_en low loads the readback register from rb_sel, where slice k sits at bits 7k+6..7k. The first bit presented afterwards is bit 6 of slice 68.
- R7: While scan_en is high, sdout shows the current readback bit and each serial edge advances it by one bit. The order is slice 68 down to slice 0, each word MSB first, and zeros follow after the 483rd bit.
- R8: While ser_mode is low, serial edges are ignored: no write is issued, sdout is low, and the word, delay-line and readback contents are kept for when serial mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | Serial mode select; the port is idle when low |
| sclk | input | 1 | Serial clock, acted on at its rising edges |
| sdin | input | 1 | Serial data input |
| load | input | 1 | Marks the last bit of a word to be written |
| scan_en | input | 1 | Low: each edge captures the readback; high: readback shifts out |
| rb_sel | input | 483 | Active selections of the 69 slices, 7 bits each |
| wr_en | output | 1 | One-cycle shadow-write request |
| wr_out_id | output | 7 | Output number of the write request |
| wr_in_id | output | 7 | Input number of the write request |
| sdout | output | 1 | Delayed chain data, or readback data while scan_en is high |

## Verification
A delay line that is one stage off, or a word that is assembled from the wrong end, shows at once. sdout disagrees within 14 serial edges, and the next load writes a wrong output or input number. A readback register that is loaded with the slices in the wrong order, or that shifts at the wrong moment, corrupts the very first readback bit or one of the next 482. The reference model compares sdout and the write port on every system clock, so a fault that slips one system cycle is caught in that cycle.

// File: rtl/xpt_serial_port.sv
module xpt_serial_port #(
  parameter int ID_W     = 7,
  parameter int N_SLICES = 69
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_mode,
  input  logic                       sclk,
  input  logic                       sdin,
  input  logic                       load,
  input  logic                       scan_en,
  input  logic [ID_W*N_SLICES-1:0]   rb_sel,
  output logic                       wr_en,
  output logic [ID_W-1:0]            wr_out_id,
  output logic [ID_W-1:0]            wr_in_id,
  output logic                       sdout
);
  localparam int WORD_W = 2 * ID_W;
  localparam int RB_W   = ID_W * N_SLICES;

  logic [2:0]        sclk_sy;
  logic [1:0]        ser_sy, sdin_sy, load_sy, scan_sy;
  logic [WORD_W-1:0] word_sh;
  logic              dly_q;
  logic [RB_W-1:0]   rb_sh;

  wire ser_on = ser_sy[1];
  wire rise   = ser_on & sclk_sy[1] & ~sclk_sy[2];
  wire [WORD_W-1:0] next_word = {word_sh[WORD_W-2:0], sdin_sy[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0;
      ser_sy  <= '0;
      sdin_sy <= '0;
      load_sy <= '0;
      scan_sy <= '0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk};
      ser_sy  <= {ser_sy[0], ser_mode};
      sdin_sy <= {sdin_sy[0], sdin};
      load_sy <= {load_sy[0], load};
      scan_sy <= {scan_sy[0], scan_en};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      word_sh <= '0;
      dly_q   <= 1'b0;
    end else if (rise) begin
      word_sh <= next_word;
      dly_q   <= word_sh[WORD_W-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_out_id <= '0;
      wr_in_id  <= '0;
    end else begin
      wr_en <= rise & load_sy[1];
      if (rise && load_sy[1]) begin
        wr_out_id <= next_word[WORD_W-1:ID_W];
        wr_in_id  <= next_word[ID_W-1:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      rb_sh <= '0;
    else if (rise)
      rb_sh <= scan_sy[1] ? {rb_sh[RB_W-2:0], 1'b0} : rb_sel;

  assign sdout = ser_on & (scan_sy[1] ? rb_sh[RB_W-1] : dly_q);

  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_wr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(load_sy[1] && ser_on));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_on |=> ($stable(word_sh) && $stable(rb_sh) && $stable(dly_q) && !wr_en));
  p_word_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_sy[1] && !sclk_sy[2]) |=> $stable(word_sh));
  p_rb_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_sy[1] && !sclk_sy[2]) |=> $stable(rb_sh));
endmodule

// File: tb/xpt_serial_port_bench.sv
`timescale 1ns/1ps
module xpt_serial_port_bench;
  localparam int ID_W = 7;
  localparam int NS   = 69;
  localparam int RBW  = ID_W * NS;

  logic clk = 0, rst_n = 0;
  logic ser_mode = 0, sclk = 0, sdin = 0, load = 0, scan_en = 0;
  logic [RBW-1:0] rb_sel = '0;
  logic wr_en, sdout;
  logic [ID_W-1:0] wr_out_id, wr_in_id;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xpt_serial_port #(.ID_W(ID_W), .N_SLICES(NS)) u_xpt_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .sclk(sclk), .sdin(sdin),
    .load(load), .scan_en(scan_en), .rb_sel(rb_sel), .wr_en(wr_en),
    .wr_out_id(wr_out_id), .wr_in_id(wr_in_id), .sdout(sdout));

  // reference model: history of sampled inputs {ser, sclk, sdin, load, scan}
  logic [4:0] h1, h2, h3;
  int m_word;
  bit chain_q[$];
  bit rbq[$];
  bit chain_out;
  bit m_wr;
  int m_out, m_in;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    h1 = 0; h2 = 0; h3 = 0; m_word = 0; m_wr = 0; m_out = 0; m_in = 0;
    chain_out = 0;
    chain_q.delete();
    for (int i = 0; i < 14; i++) chain_q.push_back(1'b0);
    rbq.delete();
    for (int i = 0; i < RBW; i++) rbq.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      m_wr = 0;
      if (h2[4] && h2[3] && !h3[3]) begin
        bit b;
        b = h2[2];
        m_word = ((m_word << 1) | b) & 16383;
        chain_q.push_back(b);
        chain_out = chain_q.pop_front();
        if (h2[1]) begin
          m_wr = 1; m_out = m_word >> 7; m_in = m_word & 127;
        end
        if (h2[0]) begin
          void'(rbq.pop_front());
          rbq.push_back(1'b0);
        end else begin
          rbq.delete();
          for (int s = NS - 1; s >= 0; s--)
            for (int k = ID_W - 1; k >= 0; k--)
              rbq.push_back(rb_sel[s*ID_W + k]);
        end
      end
      h3 = h2; h2 = h1; h1 = {ser_mode, sclk, sdin, load, scan_en};
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n) begin
    bit exp_out;
    string t;
    exp_out = h2[4] ? (h2[0] ? rbq[0] : chain_out) : 1'b0;
    t = !h2[4] ? "R8 sdout" : (h2[0] ? "R7 sdout" : "R5 sdout");
    check(t, sdout, exp_out);
    check(h2[4] ? "R4 wr_en" : "R8 wr_en", wr_en, m_wr);
    if (m_wr) begin
      check("R3 wr_out_id", wr_out_id, m_out);
      check("R3 wr_in_id", wr_in_id, m_in);
    end
  end

  task automatic sedge(input bit b, input bit ld, input bit sc, input bit lat_chk = 0);
    @(negedge clk);
    sclk = 0; sdin = b; load = ld; scan_en = sc;
    repeat (3) @(negedge clk);
    sclk = 1;
    if (lat_chk) begin
      @(negedge clk);
      @(negedge clk); check("R2 wr_en before P+2", wr_en, 0);
      @(negedge clk); check("R2 wr_en after P+2", wr_en, 1);
    end else
      repeat (3) @(negedge clk);
  endtask

  task automatic send_word(input int o, input int i, input bit lat_chk = 0);
    int w;
    w = (o << 7) | i;
    for (int k = 13; k >= 0; k--)
      sedge(w[k], k == 0, 1'b0, lat_chk && k == 0);
    @(negedge clk); load = 0;
  endtask

  initial begin
    for (int k = 0; k < NS; k++) rb_sel[k*ID_W +: ID_W] = ID_W'((k * 37 + 11) % 128);
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 sdout after reset", sdout, 0);
    check("R1 wr_en after reset", wr_en, 0);
    ser_mode = 1;
    repeat (4) @(negedge clk);
    send_word(5, 17, 1);
    send_word(68, 0);
    send_word(127, 127);
    send_word(42, 85);
    for (int n = 0; n < 40; n++) sedge(1'((n * 7 + 3) % 5 < 2), 1'b0, 1'b0);
    // readback capture and scan
    sedge(1'b0, 1'b0, 1'b0);
    @(negedge clk); scan_en = 1;
    repeat (3) @(negedge clk);
    check("R6 first readback bit", sdout, rb_sel[68*ID_W + 6]);
    for (int n = 0; n < RBW + 6; n++) sedge(1'b1, 1'b0, 1'b1);
    // serial mode off: edges with load must do nothing
    @(negedge clk); ser_mode = 0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 20; n++) sedge(1'b1, 1'b1, 1'b0);
    check("R8 sdout idle", sdout, 0);
    ser_mode = 1;
    repeat (3) @(negedge clk);
    send_word(3, 99);
    for (int k = 0; k < NS; k++) rb_sel[k*ID_W +: ID_W] = ID_W'((k * 53 + 90) % 128);
    sedge(1'b1, 1'b1, 1'b0);
    for (int n = 0; n < 30; n++) sedge(1'b0, 1'b0, 1'b1);
    repeat (8) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule